// File: doc/BRIEF.md
# Phase-Correct PWM Timer Channel

This block is an 8-bit timer channel that counts up and then back down. It makes a waveform whose pulse stays centred on the count's turning points. A prescaler set by a three-bit select code drives the counter. The counter climbs from 0 to 255, turns round, falls back to 0 and repeats. Each step takes one prescaled tick, so a full period takes 510 ticks.

The compare value goes into a buffer and becomes active only when the counter reaches the top. A waveform change in the middle of a period therefore cannot leave an odd-shaped pulse. A two-bit output mode disconnects the waveform, passes it through or inverts it. When a mode is selected, the channel claims the pin, and it drives the pin only if the direction enable is also high.

Two extreme compare values give steady levels. A period that passes without an up-count match is closed at the bottom by a forced transition, which keeps the waveform symmetric. Sticky flags report arrivals at the bottom and compare matches. Writing a 1 clears a flag.

Top module: `pcpwm_channel`

## Requirements
- R1: After reset the count is 0 and moves upward. Each prescaled tick moves it by exactly one step. It turns down only on arriving at 255 and turns up only on arriving at 0, so the sequence is 0,1,...,255,254,...,1,0,1,...
- R2: The select code is written with `cfg_we`. Code 0 stops the counter. Codes 1..7 divide the system clock by 1, 8, 32, 64, 128, 256 and 1024. A write restarts the divider, so with ratio D the first step under the new code falls on the D-th clock edge after the edge that loads it.
- R3: A write to `cmp_wdata` goes only into a buffer. The active compare value takes the buffer contents on the tick where the count arrives at 255, and that new value already applies to the match test on that same tick.
- R4: In modes 2'b10 and 2'b01 (true polarity), with an active compare value from 1 to 254, the level goes low when the count arrives at the compare value while rising. It goes high when the count arrives at that value while falling.
- R5: In true polarity, an active compare value of 0 holds the output low throughout, and 255 holds it high throughout.
- R6: Mode 2'b11 gives the complement of the true-polarity waveform, so a compare value of 0 gives a steady high and 255 a steady low.
- R7: In true polarity, with an active compare value from 1 to 254, a count period that saw no rising-count match ends with the output forced low on arrival at 0. This covers the compare value leaving 255 and the count starting above the compare value.
- R8: `pin_override` is high exactly when the mode is not 2'b00. `pin_drive` is `pin_override` ANDed with `dir_en`. In mode 2'b00 `pwm_out` is 0.
- R9: `ovf_flag` is set on each tick that arrives at 0. `cmp_flag` is set on each tick that arrives at the active compare value, in either direction. Both flags hold until cleared by a 1 on `ovf_clr` or `cmp_clr`, and a set in the same cycle as a clear wins.
- R10: Reset leaves the counter at 0 and stopped, the compare buffer and active value at 0, the mode at 2'b00 and both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmp_we | input | 1 | Write strobe for the compare buffer |
| cmp_wdata | input | 8 | Compare value to buffer |
| cfg_we | input | 1 | Write strobe for select code and output mode |
| cfg_clksel | input | 3 | Prescale select code |
| cfg_outmode | input | 2 | Output mode: 00 off, 01/10 true, 11 inverted |
| dir_en | input | 1 | Pin direction enable |
| ovf_clr | input | 1 | Clear for the bottom flag |
| cmp_clr | input | 1 | Clear for the compare flag |
| count | output | 8 | Present counter value |
| pwm_out | output | 1 | Waveform level |
| pin_override | output | 1 | Channel claims the pin |
| pin_drive | output | 1 | Pin driver enable |
| ovf_flag | output | 1 | Sticky bottom-arrival flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench builds the channel with its default widths: an 8-bit counter and a 10-bit prescaler. With those widths the whole 0 to 255 triangle and both extreme compare values can be reached with the divide-by-1 setting in a few hundred clocks. The 10-bit divider still leaves the divide-by-1024 code cheap enough to be observed stepping. A behavioural model tracks the count, the buffered compare value, the period's match history and the flags on every clock. Directed checks aim at the forced bottom transition, the buffered load at the top and the prescaler restart.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_ALT    = 2'b01,
    OM_NONINV = 2'b10,
    OM_INV    = 2'b11
  } outmode_e;

  // Clock division for each select code; 0 means the counter is halted.
  function automatic int unsigned divide_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return 1;
      3'd2:    return 8;
      3'd3:    return 32;
      3'd4:    return 64;
      3'd5:    return 128;
      3'd6:    return 256;
      3'd7:    return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic logic mode_claims_pin(input outmode_e m);
    return m != OM_OFF;
  endfunction

  function automatic logic mode_inverts(input outmode_e m);
    return m == OM_INV;
  endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
  import pcpwm_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic             tick
);

  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] last_val;
  logic             running;

  always_comb begin
    running  = (sel_q != '0);
    last_val = PRE_W'(divide_ratio(sel_q) - 1);
    tick     = running && (pre_cnt == last_val);
  end

  // A select write restarts the divider from zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      pre_cnt <= '0;
    end else if (cfg_we) begin
      sel_q   <= cfg_sel;
      pre_cnt <= '0;
    end else if (running) begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
    end
  end

  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pre_cnt <= last_val));

  assert_halt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> !tick);

endmodule

// File: rtl/pcpwm_updown.sv
module pcpwm_updown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             arr_up,
  output logic             at_top,
  output logic             at_bot,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] cmp_nxt
);

  localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] BOTV = '0;

  logic             up_q;
  logic [CNT_W-1:0] cmp_buf;

  function automatic logic [CNT_W-1:0] step_value(input logic [CNT_W-1:0] v,
                                                  input logic rising);
    return rising ? v + 1'b1 : v - 1'b1;
  endfunction

  always_comb begin
    cnt_nxt = step_value(cnt, up_q);
    arr_up  = up_q;
    at_top  = tick && (cnt_nxt == TOPV);
    at_bot  = tick && (cnt_nxt == BOTV);
    cmp_nxt = at_top ? cmp_buf : cmp_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= BOTV;
      up_q <= 1'b1;
    end else if (tick) begin
      cnt <= cnt_nxt;
      if (cnt_nxt == TOPV)      up_q <= 1'b0;
      else if (cnt_nxt == BOTV) up_q <= 1'b1;
    end
  end

  // Buffered compare value: loaded into the active copy at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_we) cmp_buf <= cmp_wdata;
      if (at_top) cmp_act <= cmp_buf;
    end
  end

  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (((cnt - $past(cnt)) == CNT_W'(1)) || (($past(cnt) - cnt) == CNT_W'(1))));

  assert_top_turns_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOPV) |-> !up_q);

  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_load_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !at_top |=> $stable(cmp_act));

endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arr_up,
  input  logic             at_bot,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp_nxt,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             level,
  output logic             match_evt
);

  localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};

  logic up_match;
  logic dn_match;
  logic pin_floor;
  logic pin_ceil;
  logic mid_range;
  logic hit_q;
  logic level_nxt;

  always_comb begin
    match_evt = tick && (cnt_nxt == cmp_nxt);
    up_match  = match_evt && arr_up;
    dn_match  = match_evt && !arr_up;
    pin_floor = (cmp_nxt == '0);
    pin_ceil  = (cmp_nxt == TOPV);
    mid_range = !pin_floor && !pin_ceil;
  end

  // Rule order: extremes, then matches, then the forced close at the bottom.
  always_comb begin
    level_nxt = level;
    if (tick) begin
      if (pin_floor)               level_nxt = 1'b0;
      else if (pin_ceil)           level_nxt = 1'b1;
      else if (up_match)           level_nxt = 1'b0;
      else if (dn_match)           level_nxt = 1'b1;
      else if (at_bot && !hit_q)   level_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      level <= level_nxt;
      if (at_bot)        hit_q <= 1'b0;
      else if (up_match) hit_q <= 1'b1;
    end
  end

  assert_floor_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0) |-> !level);

  assert_ceil_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == TOPV) |-> level);

  assert_rise_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_match && mid_range) |=> !level);

  assert_fall_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_match && mid_range) |=> level);

  assert_bottom_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_bot && !hit_q && mid_range) |=> !level);

endmodule

// File: rtl/pcpwm_flags.sv
module pcpwm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic cmp_evt,
  input  logic ovf_clr,
  input  logic cmp_clr,
  output logic ovf_flag,
  output logic cmp_flag
);

  function automatic logic sticky(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ovf_flag <= sticky(ovf_flag, ovf_evt, ovf_clr);
      cmp_flag <= sticky(cmp_flag, cmp_evt, cmp_clr);
    end
  end

  assert_ovf_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  assert_cmp_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_flag);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  assert_cmp_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !cmp_clr) |=> cmp_flag);

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_clksel,
  input  logic [1:0]       cfg_outmode,
  input  logic             dir_en,
  input  logic             ovf_clr,
  input  logic             cmp_clr,
  output logic [CNT_W-1:0] count,
  output logic             pwm_out,
  output logic             pin_override,
  output logic             pin_drive,
  output logic             ovf_flag,
  output logic             cmp_flag
);

  // Named internal events, exposed for the assertions.
  logic             tick;
  logic [CNT_W-1:0] cnt_nxt;
  logic             arr_up;
  logic             at_top;
  logic             at_bot;
  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] cmp_nxt;
  logic             level;
  logic             match_evt;
  outmode_e         mode_q;

  pcpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_clksel),
    .tick    (tick)
  );

  pcpwm_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .cnt       (count),
    .cnt_nxt   (cnt_nxt),
    .arr_up    (arr_up),
    .at_top    (at_top),
    .at_bot    (at_bot),
    .cmp_act   (cmp_act),
    .cmp_nxt   (cmp_nxt)
  );

  pcpwm_wavegen #(.CNT_W(CNT_W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .arr_up    (arr_up),
    .at_bot    (at_bot),
    .cnt_nxt   (cnt_nxt),
    .cmp_nxt   (cmp_nxt),
    .cmp_act   (cmp_act),
    .level     (level),
    .match_evt (match_evt)
  );

  pcpwm_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_evt  (at_bot),
    .cmp_evt  (match_evt),
    .ovf_clr  (ovf_clr),
    .cmp_clr  (cmp_clr),
    .ovf_flag (ovf_flag),
    .cmp_flag (cmp_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= OM_OFF;
    else if (cfg_we) mode_q <= outmode_e'(cfg_outmode);
  end

  always_comb begin
    pin_override = mode_claims_pin(mode_q);
    pin_drive    = pin_override && dir_en;
    if (!pin_override)            pwm_out = 1'b0;
    else if (mode_inverts(mode_q)) pwm_out = !level;
    else                           pwm_out = level;
  end

  assert_drive_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive |-> (pin_override && dir_en));

  assert_top_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |=> (count == {CNT_W{1'b1}}));

endmodule

// File: tb/pcpwm_channel_bench.sv
module pcpwm_channel_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_we = 1'b0;
  logic [7:0] cmp_wdata = 8'd0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_clksel = 3'd0;
  logic [1:0] cfg_outmode = 2'd0;
  logic       dir_en = 1'b0;
  logic       ovf_clr = 1'b0;
  logic       cmp_clr = 1'b0;
  logic [7:0] count;
  logic       pwm_out, pin_override, pin_drive, ovf_flag, cmp_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  pcpwm_channel u_pcpwm_channel (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .cfg_we(cfg_we), .cfg_clksel(cfg_clksel), .cfg_outmode(cfg_outmode),
    .dir_en(dir_en), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .count(count),
    .pwm_out(pwm_out), .pin_override(pin_override), .pin_drive(pin_drive),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_cnt, m_rise, m_act, m_buf, m_sel, m_mode, m_pre, m_lvl, m_seen, m_ovf, m_cmpf;

  function automatic int ratio_of(input int s);
    case (s)
      1: return 1;     2: return 8;     3: return 32;   4: return 64;
      5: return 128;   6: return 256;   7: return 1024; default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rise = 1; m_act = 0; m_buf = 0; m_sel = 0; m_mode = 0;
      m_pre = 0; m_lvl = 0; m_seen = 0; m_ovf = 0; m_cmpf = 0;
    end else begin
      int step, nxt, cmpv, hit, ovf_e, cmp_e;
      step = (m_sel != 0) && (m_pre == ratio_of(m_sel) - 1);
      ovf_e = 0; cmp_e = 0;
      if (step) begin
        nxt  = m_rise ? m_cnt + 1 : m_cnt - 1;
        cmpv = (nxt == 255) ? m_buf : m_act;
        hit  = (nxt == cmpv);
        cmp_e = hit;
        ovf_e = (nxt == 0);
        if (cmpv == 0)                 m_lvl = 0;
        else if (cmpv == 255)          m_lvl = 1;
        else if (hit && m_rise)        m_lvl = 0;
        else if (hit && !m_rise)       m_lvl = 1;
        else if (nxt == 0 && !m_seen)  m_lvl = 0;
        if (nxt == 0) m_seen = 0;
        else if (hit && m_rise) m_seen = 1;
        if (nxt == 255) begin m_rise = 0; m_act = m_buf; end
        if (nxt == 0) m_rise = 1;
        m_cnt = nxt;
      end
      if (cfg_we) begin m_sel = cfg_clksel; m_pre = 0; m_mode = cfg_outmode; end
      else if (m_sel != 0) m_pre = step ? 0 : m_pre + 1;
      if (cmp_we) m_buf = cmp_wdata;
      m_ovf  = ovf_e ? 1 : (ovf_clr ? 0 : m_ovf);
      m_cmpf = cmp_e ? 1 : (cmp_clr ? 0 : m_cmpf);
    end
  end

  // Per-clock comparison, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_pwm, e_ovr;
      e_ovr = (m_mode != 0);
      e_pwm = !e_ovr ? 0 : (m_mode == 3 ? !m_lvl : m_lvl);
      check("R1/R2 count", count, m_cnt);
      check("R3-R7 pwm_out", pwm_out, e_pwm);
      check("R8 pin_override", pin_override, e_ovr);
      check("R8 pin_drive", pin_drive, e_ovr && dir_en);
      check("R9 ovf_flag", ovf_flag, m_ovf);
      check("R9 cmp_flag", cmp_flag, m_cmpf);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic write_cmp(input int v);
    @(posedge clk); #1;
    cmp_we = 1'b1; cmp_wdata = 8'(v);
    @(posedge clk); #1;
    cmp_we = 1'b0;
  endtask

  task automatic write_cfg(input int sel, input int mode);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_clksel = 3'(sel); cfg_outmode = 2'(mode);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (count != 8'(v));
  endtask

  task automatic count_level(input int n, input int lvl, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out == lvl) hits++;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int c0, hits;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset count", count, 0);
    check("R10 reset pwm_out", pwm_out, 0);
    check("R10 reset override", pin_override, 0);
    check("R10 reset ovf_flag", ovf_flag, 0);
    check("R10 reset cmp_flag", cmp_flag, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    run(20);
    check("R10 halted after reset", count, 0);

    // R4 / R1: true polarity, compare 100, divide by 1
    dir_en = 1'b1;
    write_cmp(100);
    write_cfg(1, 2);
    wait_cnt(255); wait_cnt(0); wait_cnt(255); wait_cnt(0);
    wait_cnt(99);  check("R4 below match rising high", pwm_out, 1);
    @(negedge clk); check("R4 rising match clears", pwm_out, 0);
    check("R1 count at match", count, 100);
    wait_cnt(255); check("R1 reaches top", count, 255);
    @(negedge clk); check("R1 turns down", count, 254);
    wait_cnt(101); check("R4 above match falling low", pwm_out, 0);
    @(negedge clk); check("R4 falling match sets", pwm_out, 1);
    check("R9 cmp flag on match", cmp_flag, 1);
    wait_cnt(0);   check("R9 ovf flag at bottom", ovf_flag, 1);
    @(posedge clk); #1 ovf_clr = 1'b1; cmp_clr = 1'b1;
    @(posedge clk); #1 ovf_clr = 1'b0; cmp_clr = 1'b0;
    @(negedge clk);
    check("R9 ovf flag cleared", ovf_flag, 0);
    check("R9 cmp flag cleared", cmp_flag, 0);

    // R3: buffered write does not act before the top
    wait_cnt(10);
    write_cmp(200);
    wait_cnt(150); check("R3 old compare still active rising", pwm_out, 0);
    wait_cnt(255); wait_cnt(150);
    check("R3 new compare active falling", pwm_out, 1);

    // R5: compare 255 holds high
    write_cmp(255);
    wait_cnt(0); wait_cnt(255);
    count_level(510, 0, hits);
    check("R5 compare 255 never low", hits, 0);

    // R7: compare leaves 255, forced low at bottom
    write_cmp(60);
    wait_cnt(0); wait_cnt(255);
    wait_cnt(1);   check("R7 high just before bottom", pwm_out, 1);
    @(negedge clk);
    check("R7 at bottom count", count, 0);
    check("R7 forced low at bottom", pwm_out, 0);
    run(600);

    // R5: compare 0 holds low
    write_cmp(0);
    wait_cnt(0); wait_cnt(255);
    count_level(510, 1, hits);
    check("R5 compare 0 never high", hits, 0);

    // R6: inverted mode
    write_cfg(1, 3);
    count_level(300, 0, hits);
    check("R6 inverted compare 0 never low", hits, 0);
    write_cmp(100);
    run(1100);
    write_cmp(255);
    wait_cnt(0); wait_cnt(255);
    count_level(510, 1, hits);
    check("R6 inverted compare 255 never high", hits, 0);
    write_cmp(140);
    run(1100);

    // R8: mode 00 and alternate true mode 01
    write_cfg(1, 0);
    @(negedge clk);
    check("R8 off mode override", pin_override, 0);
    check("R8 off mode drive", pin_drive, 0);
    check("R8 off mode pwm", pwm_out, 0);
    run(300);
    write_cfg(1, 1);
    dir_en = 1'b0;
    @(negedge clk);
    check("R8 claimed without direction", pin_drive, 0);
    check("R8 mode 01 claims pin", pin_override, 1);
    run(600);
    dir_en = 1'b1;

    // R2: divide by 8 restart timing
    write_cfg(2, 2);
    c0 = count;
    for (int i = 1; i <= 7; i++) begin
      @(posedge clk); @(negedge clk);
      check("R2 no step before ratio", count, c0);
    end
    @(posedge clk); @(negedge clk);
    check("R2 step on eighth edge", int'(count != 8'(c0)), 1);
    run(4200);
    // R2: other codes
    write_cfg(3, 2); run(1200);
    write_cfg(4, 2); run(700);
    write_cfg(5, 3); run(700);
    write_cfg(6, 2); run(800);
    write_cfg(7, 2); run(3100);
    write_cfg(0, 2);
    @(negedge clk); c0 = count;
    run(500);
    @(negedge clk);
    check("R2 code 0 halts", count, c0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule